// File: doc/BRIEF.md
# NAND Flash Pin-Cycle Bridge

This block sits between a simple request/acknowledge host bus and the pins of a raw 8-bit NAND flash device. Software does the flash protocol itself. Every write to the control port carries three things: a cycle type, a chip-enable request and one byte. The bridge turns that write into a single command-latch, address-latch or data-write strobe on the flash pins. The bridge never sequences a whole flash operation by itself.

To read flash data, software first writes the read-arm type. Each later read of the data port then produces one read-enable pulse and returns the byte the flash drove. A read of the control port returns the synchronised ready/busy state. The setup, strobe-low and hold widths are parameters counted in system clocks. The host acknowledge is held back until the whole strobe has finished, so two accesses never overlap on the flash pins.

Top module: `nandbr_top`

## Requirements
- R1: A control-port write with type code 0 (word bits 30:28) produces exactly one write-enable low pulse. During that pulse the command latch is high, the address latch is low, and the flash I/O carries word bits 23:16, held stable.
- R2: Type code 1 produces exactly one write-enable pulse with the address latch high and the command latch low. The flash I/O carries word bits 23:16.
- R3: Type code 3 produces exactly one write-enable pulse with both latch lines low. The flash I/O carries word bits 23:16.
- R4: Every control-port write copies word bit 31 to the chip enable. A 1 drives the active-low chip enable low, and a 0 releases it high. This holds for all eight type codes.
- R5: Type codes 2 and 4 to 7 produce no write-enable pulse and are acknowledged one cycle after the request is sampled.
- R6: After a type 2 write, each read of the data port (select = 1) produces one read-enable low pulse and no write pulse. It returns the flash byte sampled in the last low cycle in bits 23:16, with all other bits zero.
- R7: A control-port write of any type other than 2 leaves read mode. A data-port read outside read mode returns zero, produces no pulse and is acknowledged after one cycle.
- R8: A control-port read returns bit 15 set when the ready/busy input is low (busy) and clear when it is high, with all other bits zero. The input passes through two flip-flops, so a change becomes visible two clock edges later.
- R9: Every strobe has a setup of T_SETUP cycles, a low phase of exactly T_LOW cycles and a hold of T_HOLD cycles. The acknowledge for a strobe access arrives T_SETUP+T_LOW+T_HOLD+1 cycles after the request is raised.
- R10: The flash I/O output enable is high only during the setup, low and hold phases of a write strobe, for exactly T_SETUP+T_LOW+T_HOLD cycles. It is never high during a read strobe.
- R11: A write to the data port is acknowledged without any flash pulse and leaves the chip enable unchanged.
- R12: The host acknowledge is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Access request, held until acknowledged |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_sel | input | 1 | 0 = control/status port, 1 = data-read port |
| host_wdata | input | 32 | Write word: bit 31 chip enable, 30:28 type, 23:16 byte |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 32 | Read word, valid with host_ack |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_cle | output | 1 | Flash command latch enable |
| fl_ale | output | 1 | Flash address latch enable |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_re_n | output | 1 | Flash read enable, active low |
| fl_io_out | output | 8 | Byte driven to the flash I/O |
| fl_io_oe | output | 1 | Output enable for the flash I/O |
| fl_io_in | input | 8 | Byte driven by the flash |
| fl_rb_n | input | 1 | Flash ready (1) / busy (0) |

## Verification
The assertions assume a host that keeps its request steady until the acknowledge and drops it, or changes it, by the cycle that follows. They also assume the strobe timing parameters are all at least one. The bench drives every request from the falling clock edge, holds it until it sees the acknowledge, and lowers it at once, so no access is ever presented twice. The flash model changes its I/O byte only after a read-enable rising edge. This keeps the byte stable across the sampling cycle that the data-read check depends on.

// File: rtl/nandbr_pkg.sv
package nandbr_pkg;
  localparam int WORD_W   = 32;
  localparam int CE_BIT   = 31;
  localparam int TYPE_HI  = 30;
  localparam int TYPE_LO  = 28;
  localparam int BYTE_LO  = 16;
  localparam int BUSY_BIT = 15;

  localparam logic [2:0] CT_CMD  = 3'd0;
  localparam logic [2:0] CT_ADDR = 3'd1;
  localparam logic [2:0] CT_ARM  = 3'd2;
  localparam logic [2:0] CT_DATA = 3'd3;

  typedef enum logic [1:0] {K_CMD, K_ADDR, K_DATA, K_READ} op_kind_e;
  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_LOW, S_HOLD} strb_state_e;
endpackage

// File: rtl/nandbr_sync.sv
module nandbr_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/nandbr_strobe.sv
module nandbr_strobe
  import nandbr_pkg::*;
#(
  parameter int T_SETUP = 2,
  parameter int T_LOW   = 3,
  parameter int T_HOLD  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  output logic active,
  output logic low,
  output logic sample,
  output logic done
);
  localparam int TMAX = (T_SETUP > T_LOW) ? ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD)
                                          : ((T_LOW > T_HOLD) ? T_LOW : T_HOLD);
  localparam int CW   = (TMAX < 2) ? 1 : $clog2(TMAX);

  strb_state_e    st;
  logic [CW-1:0]  cnt;
  logic           last;

  assign last = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= S_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          st  <= S_SETUP;
          cnt <= CW'(T_SETUP - 1);
        end
        S_SETUP: if (last) begin
          st  <= S_LOW;
          cnt <= CW'(T_LOW - 1);
        end else cnt <= cnt - 1'b1;
        S_LOW: if (last) begin
          st  <= S_HOLD;
          cnt <= CW'(T_HOLD - 1);
        end else cnt <= cnt - 1'b1;
        default: if (last) st <= S_IDLE;
                 else      cnt <= cnt - 1'b1;
      endcase
    end
  end

  assign active = (st != S_IDLE);
  assign low    = (st == S_LOW);
  assign sample = low && last;
  assign done   = (st == S_HOLD) && last;
endmodule

// File: rtl/nandbr_top.sv
module nandbr_top
  import nandbr_pkg::*;
#(
  parameter int T_SETUP = 2,
  parameter int T_LOW   = 3,
  parameter int T_HOLD  = 2,
  parameter int IO_W    = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_req,
  input  logic            host_wr,
  input  logic            host_sel,
  input  logic [31:0]     host_wdata,
  output logic            host_ack,
  output logic [31:0]     host_rdata,
  output logic            fl_ce_n,
  output logic            fl_cle,
  output logic            fl_ale,
  output logic            fl_we_n,
  output logic            fl_re_n,
  output logic [IO_W-1:0] fl_io_out,
  output logic            fl_io_oe,
  input  logic [IO_W-1:0] fl_io_in,
  input  logic            fl_rb_n
);
  logic            ce_q, rd_mode_q, ack_q, run_q;
  op_kind_e        kind_q;
  logic [IO_W-1:0] byte_q;
  logic [31:0]     rdata_q;
  logic            rb_sync;
  logic            s_active, s_low, s_sample, s_done;
  logic [2:0]      wtype;
  logic            accept, ctl_wr, ctl_rd, dat_rd, launch_wr, launch_rd, go, is_wr;
  logic            unused_bits;

  assign unused_bits = ^{host_wdata[27:16+IO_W], host_wdata[15:0]};

  nandbr_sync #(.STAGES(2), .RST_VAL(1'b1)) u_rb_sync (
    .clk(clk), .rst(rst), .d(fl_rb_n), .q(rb_sync)
  );

  nandbr_strobe #(.T_SETUP(T_SETUP), .T_LOW(T_LOW), .T_HOLD(T_HOLD)) u_strobe (
    .clk(clk), .rst(rst), .go(go),
    .active(s_active), .low(s_low), .sample(s_sample), .done(s_done)
  );

  assign wtype     = host_wdata[TYPE_HI:TYPE_LO];
  assign accept    = host_req && !ack_q && !run_q;
  assign ctl_wr    = accept && host_wr && !host_sel;
  assign ctl_rd    = accept && !host_wr && !host_sel;
  assign dat_rd    = accept && !host_wr && host_sel;
  assign launch_wr = ctl_wr && (wtype == CT_CMD || wtype == CT_ADDR || wtype == CT_DATA);
  assign launch_rd = dat_rd && rd_mode_q;
  assign go        = launch_wr || launch_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q      <= 1'b0;
      rd_mode_q <= 1'b0;
      ack_q     <= 1'b0;
      run_q     <= 1'b0;
      kind_q    <= K_DATA;
      byte_q    <= '0;
      rdata_q   <= '0;
    end else begin
      ack_q <= 1'b0;
      if (accept) begin
        if (ctl_wr) begin
          ce_q      <= host_wdata[CE_BIT];
          rd_mode_q <= (wtype == CT_ARM);
          byte_q    <= host_wdata[BYTE_LO +: IO_W];
          case (wtype)
            CT_CMD:  kind_q <= K_CMD;
            CT_ADDR: kind_q <= K_ADDR;
            CT_DATA: kind_q <= K_DATA;
            default: kind_q <= kind_q;
          endcase
        end
        if (ctl_rd) begin
          rdata_q           <= '0;
          rdata_q[BUSY_BIT] <= !rb_sync;
        end
        if (dat_rd && !rd_mode_q) rdata_q <= '0;
        if (launch_rd) kind_q <= K_READ;
        if (go) run_q <= 1'b1;
        else    ack_q <= 1'b1;
      end
      if (s_sample && kind_q == K_READ) begin
        rdata_q                    <= '0;
        rdata_q[BYTE_LO +: IO_W]   <= fl_io_in;
      end
      if (run_q && s_done) begin
        run_q <= 1'b0;
        ack_q <= 1'b1;
      end
    end
  end

  assign is_wr      = (kind_q != K_READ);
  assign host_ack   = ack_q;
  assign host_rdata = rdata_q;
  assign fl_ce_n    = !ce_q;
  assign fl_cle     = s_active && (kind_q == K_CMD);
  assign fl_ale     = s_active && (kind_q == K_ADDR);
  assign fl_we_n    = !(s_low && is_wr);
  assign fl_re_n    = !(s_low && !is_wr);
  assign fl_io_oe   = s_active && is_wr;
  assign fl_io_out  = byte_q;
endmodule

// File: rtl/nandbr_chk.sv
module nandbr_chk #(
  parameter int T_LOW = 3,
  parameter int IO_W  = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            host_ack,
  input logic            fl_cle,
  input logic            fl_ale,
  input logic            fl_we_n,
  input logic            fl_re_n,
  input logic            fl_io_oe,
  input logic [IO_W-1:0] fl_io_out
);
  logic        strb_low;
  logic [15:0] lowrun;

  assign strb_low = !fl_we_n || !fl_re_n;

  always_ff @(posedge clk) begin
    if (rst)           lowrun <= '0;
    else if (strb_low) lowrun <= lowrun + 1'b1;
    else               lowrun <= '0;
  end

  p_latch_excl_r1: assert property (@(posedge clk) disable iff (rst)
    !(fl_cle && fl_ale));
  p_io_stable_r1: assert property (@(posedge clk) disable iff (rst)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_io_out) && $stable(fl_cle) && $stable(fl_ale)));
  p_we_re_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(!fl_we_n && !fl_re_n));
  p_low_width_r9: assert property (@(posedge clk) disable iff (rst)
    (!strb_low && lowrun != 0) |-> (lowrun == 16'(T_LOW)));
  p_oe_write_only_r10: assert property (@(posedge clk) disable iff (rst)
    fl_io_oe |-> fl_re_n);
  p_we_needs_oe_r10: assert property (@(posedge clk) disable iff (rst)
    !fl_we_n |-> fl_io_oe);
  p_ack_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    host_ack |=> !host_ack);
endmodule

bind nandbr_top nandbr_chk #(.T_LOW(T_LOW), .IO_W(IO_W)) u_chk (
  .clk(clk), .rst(rst), .host_ack(host_ack), .fl_cle(fl_cle), .fl_ale(fl_ale),
  .fl_we_n(fl_we_n), .fl_re_n(fl_re_n), .fl_io_oe(fl_io_oe), .fl_io_out(fl_io_out)
);

// File: tb/nandbr_top_test.sv
module nandbr_top_test;
  localparam int TS = 2, TL = 3, TH = 2;
  localparam int STRB_LAT = TS + TL + TH + 1;

  logic clk = 1'b0, rst = 1'b1;
  logic host_req = 1'b0, host_wr = 1'b0, host_sel = 1'b0;
  logic [31:0] host_wdata = '0;
  logic host_ack;
  logic [31:0] host_rdata;
  logic fl_ce_n, fl_cle, fl_ale, fl_we_n, fl_re_n, fl_io_oe;
  logic [7:0] fl_io_out, fl_io_in;
  logic fl_rb_n = 1'b1;

  int total = 0, bad = 0;
  int we_falls = 0, re_falls = 0, we_lows = 0, re_lows = 0, oe_cyc = 0, rd_ptr = 0;
  logic prev_we = 1'b1, prev_re = 1'b1;
  logic seen_cle, seen_ale;
  logic [7:0] seen_io;

  always #10 clk = ~clk;

  assign fl_io_in = 8'hA5 ^ 8'(rd_ptr * 59);

  nandbr_top #(.T_SETUP(TS), .T_LOW(TL), .T_HOLD(TH)) uut (
    .clk(clk), .rst(rst), .host_req(host_req), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_ack(host_ack), .host_rdata(host_rdata),
    .fl_ce_n(fl_ce_n), .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_we_n(fl_we_n),
    .fl_re_n(fl_re_n), .fl_io_out(fl_io_out), .fl_io_oe(fl_io_oe),
    .fl_io_in(fl_io_in), .fl_rb_n(fl_rb_n)
  );

  always @(negedge clk) begin
    if (!fl_we_n) begin
      we_lows++;
      seen_cle = fl_cle; seen_ale = fl_ale; seen_io = fl_io_out;
    end
    if (!fl_re_n) re_lows++;
    if (prev_we && !fl_we_n) we_falls++;
    if (prev_re && !fl_re_n) re_falls++;
    if (!prev_re && fl_re_n) rd_ptr++;
    if (fl_io_oe) oe_cyc++;
    prev_we = fl_we_n;
    prev_re = fl_re_n;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic sel, input logic wr, input logic [31:0] wd,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    host_sel = sel; host_wr = wr; host_wdata = wd; host_req = 1'b1; lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!host_ack && lat < 60);
    rd = host_rdata;
    host_req = 1'b0;
    if (lat >= 60) chk(1'b0, "R9 ack timeout", lat, 0);
    @(negedge clk);
    chk(!host_ack, "R12 ack single cycle", host_ack, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int lat, wf0, wl0, rf0, rl0, oe0, exp_ptr;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(fl_ce_n && fl_we_n && fl_re_n && !fl_io_oe && !host_ack && !fl_cle && !fl_ale,
        "R4 reset pin state", {fl_ce_n, fl_we_n, fl_re_n, fl_io_oe}, 4'b1110);

    // Sweep every type code, both chip-enable values and four bytes (R1 R2 R3 R4 R5 R9 R10)
    for (int t = 0; t < 8; t++) begin
      for (int ce = 0; ce < 2; ce++) begin
        for (int bi = 0; bi < 4; bi++) begin
          logic [7:0] b;
          bit strobe;
          b = (bi == 0) ? 8'h00 : (bi == 1) ? 8'hFF : (bi == 2) ? 8'h5A : 8'(t * 37 + ce * 11 + 3);
          strobe = (t == 0) || (t == 1) || (t == 3);
          wf0 = we_falls; wl0 = we_lows; rf0 = re_falls; oe0 = oe_cyc;
          access(1'b0, 1'b1, {ce[0], 3'(t), 4'h0, b, 16'h0}, rd, lat);
          chk(lat == (strobe ? STRB_LAT : 1), "R9 ack latency", lat, strobe ? STRB_LAT : 1);
          chk(we_falls - wf0 == int'(strobe), strobe ? "R1 R2 R3 one write pulse" : "R5 no write pulse",
              we_falls - wf0, int'(strobe));
          chk(re_falls == rf0, "R6 no read pulse on write", re_falls - rf0, 0);
          chk(fl_ce_n == !ce[0], "R4 chip enable follows bit 31", fl_ce_n, !ce[0]);
          chk(oe_cyc - oe0 == (strobe ? TS + TL + TH : 0), "R10 output enable window",
              oe_cyc - oe0, strobe ? TS + TL + TH : 0);
          if (strobe) begin
            chk(we_lows - wl0 == TL, "R9 write low width", we_lows - wl0, TL);
            chk(seen_cle == (t == 0), "R1 command latch level", seen_cle, t == 0);
            chk(seen_ale == (t == 1), "R2 address latch level", seen_ale, t == 1);
            chk(seen_io == b, "R3 byte on flash I/O", seen_io, b);
          end
        end
      end
    end

    // Read mode (R6)
    rf0 = re_falls; wf0 = we_falls;
    access(1'b0, 1'b1, {1'b1, 3'd2, 28'h0}, rd, lat);
    chk(re_falls == rf0 && we_falls == wf0, "R6 arm makes no pulse", re_falls - rf0, 0);
    exp_ptr = rd_ptr;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] eb;
      eb = 8'hA5 ^ 8'(exp_ptr * 59);
      rf0 = re_falls; rl0 = re_lows; wf0 = we_falls; oe0 = oe_cyc;
      access(1'b1, 1'b0, 32'h0, rd, lat);
      chk(rd == {8'h0, eb, 16'h0}, "R6 read data", rd, {8'h0, eb, 16'h0});
      chk(re_falls - rf0 == 1 && we_falls == wf0, "R6 one read pulse", re_falls - rf0, 1);
      chk(re_lows - rl0 == TL, "R9 read low width", re_lows - rl0, TL);
      chk(lat == STRB_LAT, "R9 read ack latency", lat, STRB_LAT);
      chk(oe_cyc == oe0, "R10 no drive during read", oe_cyc - oe0, 0);
      exp_ptr++;
    end

    // Leaving read mode (R7)
    access(1'b0, 1'b1, {1'b1, 3'd3, 4'h0, 8'h77, 16'h0}, rd, lat);
    rf0 = re_falls;
    access(1'b1, 1'b0, 32'h0, rd, lat);
    chk(rd == 32'h0, "R7 unarmed read data", rd, 0);
    chk(re_falls == rf0, "R7 unarmed read no pulse", re_falls - rf0, 0);
    chk(lat == 1, "R7 unarmed read latency", lat, 1);

    // Data-port write ignored (R11)
    wf0 = we_falls; rf0 = re_falls;
    access(1'b1, 1'b1, {1'b0, 3'd0, 4'h0, 8'h99, 16'h0}, rd, lat);
    chk(!fl_ce_n, "R11 chip enable kept", fl_ce_n, 0);
    chk(we_falls == wf0 && re_falls == rf0, "R11 no pulse", we_falls - wf0, 0);
    chk(lat == 1, "R11 latency", lat, 1);

    // Ready/busy status through two flops (R8)
    fl_rb_n = 1'b0;
    access(1'b0, 1'b0, 32'h0, rd, lat);
    chk(rd == 32'h0, "R8 sync delay", rd, 0);
    repeat (3) @(negedge clk);
    access(1'b0, 1'b0, 32'h0, rd, lat);
    chk(rd == 32'h0000_8000, "R8 busy", rd, 32'h8000);
    fl_rb_n = 1'b1;
    repeat (3) @(negedge clk);
    access(1'b0, 1'b0, 32'h0, rd, lat);
    chk(rd == 32'h0, "R8 ready", rd, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule